// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers device interrupt lines into a single interrupt request for a processor. It is built from two identical eight-line controller units. The secondary unit's request output drives one input of the primary unit, and the primary unit drives the processor's request line. This leaves fifteen device lines. Each line latches a request on a rising edge. A line can be blocked by a per-unit mask, and the lines are ranked by a fixed priority.

When the processor acknowledges, the block resolves the winning request and returns an 8-bit vector one cycle later. The vector is the owning unit's base plus the line index. A delivered line is held in service, and it blocks equal and lower priority lines of its unit until software writes an end-of-interrupt command. A request that came through the secondary unit holds a line in service in both units, so software must clear both.

Software reaches each unit through two addresses, command and data. The data address loads the mask. The command address accepts an end-of-interrupt code and a base-load form.

Top module: `cpic_top`

## Requirements
- R1: After reset `int_o` and `vec_vld_o` are 0, all masks are clear, and the bases are 0 (primary) and 8 (secondary). Primary line 0 then yields vector 0 and secondary line 0 yields vector 8.
- R2: A 0-to-1 transition on a device line latches one request. A line held high produces no further request until it falls and rises again.
- R3: `int_o` is a register that is 1 when the primary unit has a deliverable request. It reads 0 in the cycle after an acknowledge.
- R4: An acknowledge on `ack_i` gives `vec_vld_o` = 1 for exactly the next cycle, with `vec_o` = base + line index of the winner.
- R5: Among the pending unmasked lines of a unit, the lowest index wins (line 0 highest, line 7 lowest).
- R6: A pending line is delivered only if its index is lower than every in-service line of its unit. A higher line therefore nests over a lower one in service, and equal or lower lines wait.
- R7: Writing 0x20 to a unit's command address (`reg_addr_i`=0) clears only that unit's highest-priority (lowest index) in-service line.
- R8: Writing to a unit's data address (`reg_addr_i`=1) loads its mask from `reg_wdata_i[7:0]`, where bit n = 1 blocks line n. A masked request stays latched and is delivered after it is unmasked.
- R9: A command write with bit 0 = 1 loads that unit's base with `reg_wdata_i & 0xF8` (0x21 gives 32, 0x29 gives 40). A command value that is neither 0x20 nor has bit 0 set has no effect.
- R10: Secondary requests enter through primary line 2, and their vector comes from the secondary base and secondary line index. Primary line 2 stays in service until a primary end-of-interrupt, so both units need one.
- R11: `pri_irq_i[2]` is ignored. Primary line 2 is driven only by the secondary unit.
- R12: An acknowledge with no deliverable request returns primary base + 7 and changes no request or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_irq_i | input | 8 | Primary unit device lines (bit 2 unused) |
| sec_irq_i | input | 8 | Secondary unit device lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_unit_i | input | 1 | Unit select: 0 primary, 1 secondary |
| reg_addr_i | input | 1 | Address: 0 command, 1 data (mask) |
| reg_wdata_i | input | 8 | Write data |
| ack_i | input | 1 | Processor acknowledge, one-cycle pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_vld_o | output | 1 | Vector valid, the cycle after an acknowledge |
| vec_o | output | 8 | Vector number |

## Verification
The bench targets nesting. A lower line must stay blocked behind a higher one in service, and a non-specific end-of-interrupt that cleared the wrong bit would release that lower line too early. The cascade path is driven with a secondary end-of-interrupt alone. A design that did not keep primary line 2 in service would then let primary lines 3 to 7 through. The bench also holds a line high across an end-of-interrupt, where a level-triggered design would re-deliver. Finally it issues an acknowledge with nothing deliverable, where a design that touched state would lose a blocked request or leave a stale in-service bit.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  localparam logic [7:0] CMD_EOI = 8'h20;

  typedef enum logic {
    SEL_PRI = 1'b0,
    SEL_SEC = 1'b1
  } unit_sel_e;

  typedef enum logic {
    ADR_CMD  = 1'b0,
    ADR_DATA = 1'b1
  } reg_adr_e;
endpackage

// File: rtl/cpic_prio.sv
module cpic_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |bits_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cpic_unit.sv
module cpic_unit
  import cpic_pkg::*;
#(
  parameter int unsigned N           = 8,
  parameter int unsigned DW          = 8,
  parameter logic [N-1:0] LEVEL_LINES = '0,
  parameter logic [DW-1:0] RST_BASE   = '0,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_i,
  input  logic          cmd_wr_i,
  input  logic          dat_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic          win_o,
  output logic [IW-1:0] win_idx_o,
  output logic [DW-1:0] base_o
);
  logic [N-1:0]  prev_q, req_q, isr_q, mask_q;
  logic [DW-1:0] base_q;
  logic [N-1:0]  req_eff, pend, rise, ack_vec, eoi_vec;
  logic          pend_any, isr_any;
  logic [IW-1:0] pend_idx, isr_idx;
  logic          win;

  // edge lines are latched, level lines follow their input directly
  assign req_eff = (req_q & ~LEVEL_LINES) | (irq_i & LEVEL_LINES);
  assign pend    = req_eff & ~mask_q;
  assign rise    = irq_i & ~prev_q & ~LEVEL_LINES;

  cpic_prio #(.N(N)) u_pend_enc (.bits_i(pend),  .any_o(pend_any), .idx_o(pend_idx));
  cpic_prio #(.N(N)) u_isr_enc  (.bits_i(isr_q), .any_o(isr_any),  .idx_o(isr_idx));

  assign win = pend_any && (!isr_any || (pend_idx < isr_idx));

  assign ack_vec = (ack_i && win) ? ({{(N-1){1'b0}}, 1'b1} << pend_idx) : '0;
  assign eoi_vec = (cmd_wr_i && (wdata_i == DW'(CMD_EOI)) && isr_any)
                   ? ({{(N-1){1'b0}}, 1'b1} << isr_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      req_q  <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= RST_BASE;
    end else begin
      prev_q <= irq_i;
      req_q  <= (req_q & ~ack_vec) | rise;
      isr_q  <= (isr_q & ~eoi_vec) | ack_vec;
      if (dat_wr_i) mask_q <= wdata_i[N-1:0];
      if (cmd_wr_i && wdata_i[0]) base_q <= {wdata_i[DW-1:IW], {IW{1'b0}}};
    end
  end

  assign win_o     = win;
  assign win_idx_o = pend_idx;
  assign base_o    = base_q;
endmodule

// File: rtl/cpic_top.sv
module cpic_top
  import cpic_pkg::*;
#(
  parameter int unsigned NLINES   = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned CAS_LINE = 2,
  localparam int unsigned IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pri_irq_i,
  input  logic [NLINES-1:0] sec_irq_i,
  input  logic              reg_wr_i,
  input  logic              reg_unit_i,
  input  logic              reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              ack_i,
  output logic              int_o,
  output logic              vec_vld_o,
  output logic [DW-1:0]     vec_o
);
  localparam logic [NLINES-1:0] CAS_MASK = NLINES'(1) << CAS_LINE;

  logic              pri_cmd, pri_dat, sec_cmd, sec_dat;
  logic              p_win, s_win, sec_ack;
  logic [IW-1:0]     p_idx, s_idx;
  logic [DW-1:0]     p_base, s_base, vec_n;
  logic [NLINES-1:0] pri_irq_eff;
  logic              int_q, vld_q;
  logic [DW-1:0]     vec_q;

  assign pri_cmd = reg_wr_i && (reg_unit_i == SEL_PRI) && (reg_addr_i == ADR_CMD);
  assign pri_dat = reg_wr_i && (reg_unit_i == SEL_PRI) && (reg_addr_i == ADR_DATA);
  assign sec_cmd = reg_wr_i && (reg_unit_i == SEL_SEC) && (reg_addr_i == ADR_CMD);
  assign sec_dat = reg_wr_i && (reg_unit_i == SEL_SEC) && (reg_addr_i == ADR_DATA);

  // cascade line is owned by the secondary unit
  assign pri_irq_eff = (pri_irq_i & ~CAS_MASK) | (CAS_MASK & {NLINES{s_win}});
  assign sec_ack     = ack_i && p_win && (p_idx == IW'(CAS_LINE));

  cpic_unit #(
    .N(NLINES), .DW(DW), .LEVEL_LINES(CAS_MASK), .RST_BASE(DW'(0))
  ) u_pri (
    .clk(clk), .rst(rst), .irq_i(pri_irq_eff),
    .cmd_wr_i(pri_cmd), .dat_wr_i(pri_dat), .wdata_i(reg_wdata_i),
    .ack_i(ack_i), .win_o(p_win), .win_idx_o(p_idx), .base_o(p_base)
  );

  cpic_unit #(
    .N(NLINES), .DW(DW), .LEVEL_LINES('0), .RST_BASE(DW'(NLINES))
  ) u_sec (
    .clk(clk), .rst(rst), .irq_i(sec_irq_i),
    .cmd_wr_i(sec_cmd), .dat_wr_i(sec_dat), .wdata_i(reg_wdata_i),
    .ack_i(sec_ack), .win_o(s_win), .win_idx_o(s_idx), .base_o(s_base)
  );

  always_comb begin
    if (!p_win)                       vec_n = p_base + DW'(NLINES - 1);
    else if (p_idx == IW'(CAS_LINE))  vec_n = s_base + DW'(s_idx);
    else                              vec_n = p_base + DW'(p_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= 1'b0;
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      int_q <= p_win && !ack_i;
      vld_q <= ack_i;
      if (ack_i) vec_q <= vec_n;
    end
  end

  assign int_o     = int_q;
  assign vec_vld_o = vld_q;
  assign vec_o     = vec_q;
endmodule

// File: rtl/cpic_chk.sv
module cpic_chk (
  input logic clk,
  input logic rst,
  input logic ack_i,
  input logic int_o,
  input logic vec_vld_o,
  input logic p_win,
  input logic s_win,
  input logic sec_ack
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!int_o && !vec_vld_o));
  p_vld_after_ack_r4: assert property (@(posedge clk) disable iff (rst) ack_i |=> vec_vld_o);
  p_vld_only_ack_r4: assert property (@(posedge clk) disable iff (rst) !ack_i |=> !vec_vld_o);
  p_int_drop_r3: assert property (@(posedge clk) disable iff (rst) ack_i |=> !int_o);
  p_int_rise_r3: assert property (@(posedge clk) disable iff (rst) (p_win && !ack_i) |=> int_o);
  p_cascade_src_r10: assert property (@(posedge clk) disable iff (rst) sec_ack |-> s_win);
endmodule

bind cpic_top cpic_chk chk_i (
  .clk(clk), .rst(rst), .ack_i(ack_i), .int_o(int_o), .vec_vld_o(vec_vld_o),
  .p_win(p_win), .s_win(s_win), .sec_ack(sec_ack)
);

// File: tb/cpic_top_tb_top.sv
`timescale 1ns/1ps
module cpic_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pri_irq = '0, sec_irq = '0;
  logic       reg_wr = 1'b0, reg_unit = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       ack = 1'b0;
  logic       int_o, vec_vld;
  logic [7:0] vec;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpic_top dut_i (
    .clk(clk), .rst(rst), .pri_irq_i(pri_irq), .sec_irq_i(sec_irq),
    .reg_wr_i(reg_wr), .reg_unit_i(reg_unit), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .ack_i(ack), .int_o(int_o),
    .vec_vld_o(vec_vld), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit unit, input bit adr, input logic [7:0] d);
    reg_unit = unit; reg_addr = adr; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    tick();
  endtask

  task automatic eoi(input bit unit);
    wr(unit, 1'b0, 8'h20);
  endtask

  task automatic fire_pri(input logic [7:0] m);
    pri_irq = pri_irq | m; tick();
    pri_irq = pri_irq & ~m; tick();
  endtask

  task automatic fire_sec(input logic [7:0] m);
    sec_irq = sec_irq | m; tick();
    sec_irq = sec_irq & ~m; tick();
  endtask

  task automatic take(input int exp, input string tag);
    ack = 1'b1; tick(); ack = 1'b0;
    chk({tag, " R4 valid"}, vec_vld, 1);
    chk({tag, " vector"}, vec, exp);
    chk("R3 int low after ack", int_o, 0);
    tick();
    chk("R4 valid one cycle", vec_vld, 0);
  endtask

  task automatic t_reset();
    chk("R1 int after reset", int_o, 0);
    chk("R1 valid after reset", vec_vld, 0);
  endtask

  task automatic t_default_base();
    fire_pri(8'h01);
    chk("R3 int on request", int_o, 1);
    take(0, "R1 primary default base");
    eoi(1'b0);
    fire_sec(8'h01);
    chk("R10 int via cascade", int_o, 1);
    take(8, "R1 secondary default base");
    eoi(1'b1); eoi(1'b0);
    chk("R7 idle after eoi", int_o, 0);
  endtask

  task automatic t_remap();
    wr(1'b0, 1'b0, 8'h21);
    wr(1'b1, 1'b0, 8'h29);
    wr(1'b0, 1'b0, 8'h40);
    fire_pri(8'h20);
    take(37, "R9 primary base 32");
    eoi(1'b0);
    fire_sec(8'h08);
    take(43, "R9 secondary base 40");
    eoi(1'b1); eoi(1'b0);
    fire_pri(8'h02);
    take(33, "R9 command 0x40 ignored");
    eoi(1'b0);
  endtask

  task automatic t_priority();
    fire_pri(8'b0100_1010);
    take(33, "R5 lowest index wins");
    chk("R6 lower waits", int_o, 0);
    eoi(1'b0);
    chk("R6 released", int_o, 1);
    take(35, "R5 next line");
    eoi(1'b0);
    take(38, "R5 last line");
    eoi(1'b0);
    chk("R5 drained", int_o, 0);
  endtask

  task automatic t_nesting();
    fire_pri(8'h10);
    take(36, "R6 first");
    fire_pri(8'h01);
    chk("R6 higher nests", int_o, 1);
    take(32, "R6 nested");
    eoi(1'b0);
    fire_pri(8'h20);
    chk("R7 line 4 still in service", int_o, 0);
    eoi(1'b0);
    chk("R7 second eoi releases", int_o, 1);
    take(37, "R7 after release");
    eoi(1'b0);
    chk("R7 idle", int_o, 0);
  endtask

  task automatic t_edge();
    pri_irq[7] = 1'b1; tick(); tick();
    chk("R2 held line requests", int_o, 1);
    take(39, "R2 held line");
    eoi(1'b0);
    chk("R2 no retrigger", int_o, 0);
    tick(); tick();
    chk("R2 still none", int_o, 0);
    pri_irq[7] = 1'b0; tick();
    fire_pri(8'h80);
    chk("R2 new edge", int_o, 1);
    take(39, "R2 new edge");
    eoi(1'b0);
  endtask

  task automatic t_mask();
    wr(1'b0, 1'b1, 8'h02);
    fire_pri(8'h02);
    chk("R8 masked blocked", int_o, 0);
    wr(1'b0, 1'b1, 8'h00);
    chk("R8 unmask delivers", int_o, 1);
    take(33, "R8 latched request");
    eoi(1'b0);
    chk("R8 idle", int_o, 0);
  endtask

  task automatic t_cascade();
    fire_sec(8'h04);
    take(42, "R10 secondary line 2");
    fire_pri(8'h08);
    chk("R10 cascade blocks line 3", int_o, 0);
    fire_pri(8'h02);
    chk("R6 line 1 nests over cascade", int_o, 1);
    take(33, "R6 nested over cascade");
    eoi(1'b0);
    chk("R10 cascade still in service", int_o, 0);
    eoi(1'b1);
    chk("R10 secondary eoi alone", int_o, 0);
    eoi(1'b0);
    chk("R10 primary eoi releases", int_o, 1);
    take(35, "R10 line 3 after dual eoi");
    eoi(1'b0);
    fire_sec(8'b0100_0010);
    take(41, "R5 secondary priority");
    eoi(1'b1);
    chk("R10 pending secondary waits", int_o, 0);
    eoi(1'b0);
    take(46, "R10 second secondary");
    eoi(1'b1); eoi(1'b0);
    chk("R10 idle", int_o, 0);
  endtask

  task automatic t_ignored();
    fire_pri(8'h04);
    chk("R11 primary line 2 input ignored", int_o, 0);
  endtask

  task automatic t_spurious();
    take(39, "R12 spurious vector");
    fire_pri(8'h10);
    take(36, "R12 setup");
    fire_pri(8'h40);
    chk("R12 line 6 blocked", int_o, 0);
    take(39, "R12 spurious while blocked");
    eoi(1'b0);
    chk("R12 request kept", int_o, 1);
    take(38, "R12 kept request");
    eoi(1'b0);
    chk("R12 idle", int_o, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_default_base();
    t_remap();
    t_priority();
    t_nesting();
    t_edge();
    t_mask();
    t_cascade();
    t_ignored();
    t_spurious();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule